// File: doc/BRIEF.md
# Little-Endian Load/Store Lane Aligner

This unit sits between a processor's execute stage and a data memory organised as 32-bit words. On the store side it takes a byte address, an access width and the source register value. One clock later it presents the word address, a four-bit byte-write mask and write data placed in the correct byte lanes. On the load side it takes the word returned by memory, the two low address bits, the access width and a signedness flag. One clock later it returns the value that goes to the destination register.

Byte order is little-endian: the byte at the lowest address sits in bits 7:0 of a word. Address arithmetic happens upstream, and so does any trap handling. The unit only reports an access whose address is not aligned to its width, and it suppresses the write for such an access.

Width code on `st_size` and `ld_size`: 2'b00 byte, 2'b01 halfword, 2'b10 word, 2'b11 reserved.

Top module: `lsu_align`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_addr`, `mem_be`, `mem_wdata`, `mem_we`, `st_misalign`, `ld_result`, `ld_done` and `ld_misalign` are all zero.
- R2: One cycle after an aligned store request, `mem_be` is 4'b0001 shifted left by `st_addr[1:0]` for a byte, 4'b0011 (offset 0) or 4'b1100 (offset 2) for a halfword, and 4'b1111 for a word.
- R3: One cycle after a store request, `mem_wdata` holds `st_data[7:0]` copied into all four lanes for a byte, `st_data[15:0]` copied into both halves for a halfword, and `st_data` unchanged for a word.
- R4: One cycle after a store request, `mem_addr` equals `st_addr` with bits 1:0 cleared.
- R5: A store is misaligned when it is a halfword with `st_addr[0]`=1 or a word with `st_addr[1:0]`≠0. One cycle later `st_misalign` is 1, `mem_be` is 0 and `mem_we` is 0. An aligned store gives `mem_we`=1 and `st_misalign`=0.
- R6: A byte load returns the byte in lane `ld_addr_lo`, that is `ld_rdata[8*off+7:8*off]`. It is sign-extended when `ld_unsigned`=0 and zero-extended when `ld_unsigned`=1.
- R7: An aligned halfword load returns `ld_rdata[15:0]` (offset 0) or `ld_rdata[31:16]` (offset 2). It is sign-extended when `ld_unsigned`=0 and zero-extended when `ld_unsigned`=1.
- R8: An aligned word load returns `ld_rdata` unchanged, whatever the value of `ld_unsigned`.
- R9: A load is misaligned under the same rule as a store. One cycle later `ld_misalign` is 1, `ld_done` is 0 and `ld_result` is 0. An aligned load gives `ld_done`=1.
- R10: The reserved width code 2'b11 is treated as misaligned on both paths.
- R11: In a cycle after one with no store request, `mem_we`, `mem_be` and `st_misalign` are 0. In a cycle after one with no load request, `ld_done` and `ld_misalign` are 0. In both cases `mem_addr`, `mem_wdata` and `ld_result` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_req | input | 1 | Store request this cycle |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 2 | Store width code |
| st_data | input | 32 | Store source value |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte-write mask |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_we | output | 1 | Write strobe (aligned store only) |
| st_misalign | output | 1 | Store address misaligned for its width |
| ld_req | input | 1 | Load data valid this cycle |
| ld_addr_lo | input | 2 | Low address bits of the load |
| ld_size | input | 2 | Load width code |
| ld_unsigned | input | 1 | 1 = zero-extend, 0 = sign-extend |
| ld_rdata | input | 32 | Word read from memory |
| ld_result | output | 32 | Value for the destination register |
| ld_done | output | 1 | Aligned load result valid |
| ld_misalign | output | 1 | Load address misaligned for its width |

## Verification
Every output comes from a single register stage. A wrong lane decode therefore shows up on `mem_be` or `ld_result` in the very next cycle, and it does not persist past the following request. The directed cases sweep all four offsets for each width so that a swapped lane or an off-by-one select changes a visible byte. Patterns with the top bit of the selected lane set, and with it clear, expose a reversed signedness choice. If the idle path fails to clear the mask or the strobe, a spurious write appears in the cycle right after the last request. If it fails to hold the data registers, `mem_addr`, `mem_wdata` or `ld_result` moves in that same cycle.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    localparam int XLEN   = 32;
    localparam int NBYTES = XLEN / 8;
    localparam int OFFW   = $clog2(NBYTES);
    localparam int HALFB  = NBYTES / 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            done;
        logic            mis;
    } ld_stage_t;

endpackage

// File: rtl/lsu_lane_mask.sv
module lsu_lane_mask
    import lsu_align_pkg::*;
(
    input  logic [1:0]      size,
    input  logic [OFFW-1:0] off,
    output logic [NBYTES-1:0] be,
    output logic            mis
);
    acc_size_e sz;
    assign sz = acc_size_e'(size);

    // Misalignment: halfword on an odd byte, word off a word boundary,
    // or the reserved code.
    always_comb begin
        unique case (sz)
            SZ_BYTE: mis = 1'b0;
            SZ_HALF: mis = off[0];
            SZ_WORD: mis = (off != '0);
            default: mis = 1'b1;
        endcase
    end

    // Per-lane enable; a misaligned access enables no lane.
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        localparam logic [OFFW-1:0] LANE = OFFW'(k);
        logic en;
        always_comb begin
            unique case (sz)
                SZ_BYTE: en = (off == LANE);
                SZ_HALF: en = !off[0] && (off[OFFW-1:1] == LANE[OFFW-1:1]);
                SZ_WORD: en = (off == '0);
                default: en = 1'b0;
            endcase
        end
        assign be[k] = en;
    end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_align_pkg::*;
(
    input  logic [1:0]      size,
    input  logic [XLEN-1:0] data,
    output logic [XLEN-1:0] wdata
);
    acc_size_e sz;
    assign sz = acc_size_e'(size);

    // Replicate the narrow source into every lane it could land in, so
    // the data path needs no shifter; the byte mask picks the lanes.
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        logic [7:0] lane_b;
        always_comb begin
            unique case (sz)
                SZ_BYTE: lane_b = data[7:0];
                SZ_HALF: lane_b = data[(k % 2)*8 +: 8];
                default: lane_b = data[k*8 +: 8];
            endcase
        end
        assign wdata[k*8 +: 8] = lane_b;
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_align_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [NBYTES-1:0] be,
    input  logic              mis,
    input  logic              uns,
    input  logic [XLEN-1:0]   rdata,
    output logic [XLEN-1:0]   result
);
    acc_size_e  sz;
    logic [7:0] sel_b;
    logic [7:0] half_lo;
    logic [7:0] half_hi;
    logic       sgn_b;
    logic       sgn_h;

    assign sz = acc_size_e'(size);

    // AND-OR lane select driven by the one-hot (or paired) byte mask.
    always_comb begin
        sel_b   = '0;
        half_lo = '0;
        half_hi = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (be[k]) begin
                sel_b = sel_b | rdata[k*8 +: 8];
                if ((k % 2) == 0) half_lo = half_lo | rdata[k*8 +: 8];
                else              half_hi = half_hi | rdata[k*8 +: 8];
            end
        end
    end

    assign sgn_b = !uns && sel_b[7];
    assign sgn_h = !uns && half_hi[7];

    always_comb begin
        if (mis) begin
            result = '0;
        end else begin
            unique case (sz)
                SZ_BYTE: result = {{(XLEN-8){sgn_b}}, sel_b};
                SZ_HALF: result = {{(XLEN-16){sgn_h}}, half_hi, half_lo};
                SZ_WORD: result = rdata;
                default: result = '0;
            endcase
        end
    end

endmodule

// File: rtl/lsu_align.sv
module lsu_align
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_req,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic [XLEN-1:0]   st_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NBYTES-1:0] mem_be,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              mem_we,
    output logic              st_misalign,
    input  logic              ld_req,
    input  logic [OFFW-1:0]   ld_addr_lo,
    input  logic [1:0]        ld_size,
    input  logic              ld_unsigned,
    input  logic [XLEN-1:0]   ld_rdata,
    output logic [XLEN-1:0]   ld_result,
    output logic              ld_done,
    output logic              ld_misalign
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [NBYTES-1:0] be;
        logic [XLEN-1:0]   wdata;
        logic              we;
        logic              mis;
    } st_stage_t;

    st_stage_t st_d, st_q;
    ld_stage_t ld_d, ld_q;

    logic [NBYTES-1:0] st_be_c;
    logic              st_mis_c;
    logic [XLEN-1:0]   st_wdata_c;
    logic [NBYTES-1:0] ld_be_c;
    logic              ld_mis_c;
    logic [XLEN-1:0]   ld_val_c;

    lsu_lane_mask u_st_mask (
        .size (st_size),
        .off  (st_addr[OFFW-1:0]),
        .be   (st_be_c),
        .mis  (st_mis_c)
    );

    lsu_store_lanes u_st_lanes (
        .size  (st_size),
        .data  (st_data),
        .wdata (st_wdata_c)
    );

    lsu_lane_mask u_ld_mask (
        .size (ld_size),
        .off  (ld_addr_lo),
        .be   (ld_be_c),
        .mis  (ld_mis_c)
    );

    lsu_load_extract u_ld_ext (
        .size   (ld_size),
        .be     (ld_be_c),
        .mis    (ld_mis_c),
        .uns    (ld_unsigned),
        .rdata  (ld_rdata),
        .result (ld_val_c)
    );

    // Next-state: strobes and flags clear when idle, data fields hold.
    always_comb begin
        st_d     = st_q;
        st_d.be  = '0;
        st_d.we  = 1'b0;
        st_d.mis = 1'b0;
        if (st_req) begin
            st_d.addr  = {st_addr[ADDR_W-1:OFFW], {OFFW{1'b0}}};
            st_d.wdata = st_wdata_c;
            st_d.be    = st_be_c;
            st_d.mis   = st_mis_c;
            st_d.we    = !st_mis_c;
        end

        ld_d      = ld_q;
        ld_d.done = 1'b0;
        ld_d.mis  = 1'b0;
        if (ld_req) begin
            ld_d.result = ld_val_c;
            ld_d.done   = !ld_mis_c;
            ld_d.mis    = ld_mis_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            ld_q <= '0;
        end else begin
            st_q <= st_d;
            ld_q <= ld_d;
        end
    end

    assign mem_addr    = st_q.addr;
    assign mem_be      = st_q.be;
    assign mem_wdata   = st_q.wdata;
    assign mem_we      = st_q.we;
    assign st_misalign = st_q.mis;
    assign ld_result   = ld_q.result;
    assign ld_done     = ld_q.done;
    assign ld_misalign = ld_q.mis;

endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_req,
    input logic [ADDR_W-1:0] st_addr,
    input logic [1:0]        st_size,
    input logic [XLEN-1:0]   st_data,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NBYTES-1:0] mem_be,
    input logic [XLEN-1:0]   mem_wdata,
    input logic              mem_we,
    input logic              st_misalign,
    input logic              ld_req,
    input logic [OFFW-1:0]   ld_addr_lo,
    input logic [1:0]        ld_size,
    input logic              ld_unsigned,
    input logic [XLEN-1:0]   ld_rdata,
    input logic [XLEN-1:0]   ld_result,
    input logic              ld_done,
    input logic              ld_misalign
);
    a_r2_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && st_size == 2'b00) |=> ($countones(mem_be) == 1));

    a_r2_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && st_size == 2'b01 && !st_addr[0]) |=> ($countones(mem_be) == 2));

    a_r3_word_data: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && st_size == 2'b10) |=> (mem_wdata == $past(st_data)));

    a_r4_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |=> (mem_addr[OFFW-1:0] == '0 &&
                    mem_addr[ADDR_W-1:OFFW] == $past(st_addr[ADDR_W-1:OFFW])));

    a_r5_mis_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        st_misalign |-> (mem_be == '0 && !mem_we));

    a_r5_we_has_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be != '0 && !st_misalign));

    a_r6_lbu_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && ld_size == 2'b00 && ld_unsigned) |=> (ld_result[XLEN-1:8] == '0));

    a_r8_word_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && ld_size == 2'b10 && ld_addr_lo == '0) |=> (ld_result == $past(ld_rdata)));

    a_r9_mis_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_misalign |-> (ld_result == '0 && !ld_done));

    a_r11_store_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !st_req |=> (!mem_we && mem_be == '0 && !st_misalign && $stable(mem_wdata)));

    a_r11_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_req |=> (!ld_done && !ld_misalign && $stable(ld_result)));

endmodule

bind lsu_align lsu_align_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_req      (st_req),
    .st_addr     (st_addr),
    .st_size     (st_size),
    .st_data     (st_data),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .mem_wdata   (mem_wdata),
    .mem_we      (mem_we),
    .st_misalign (st_misalign),
    .ld_req      (ld_req),
    .ld_addr_lo  (ld_addr_lo),
    .ld_size     (ld_size),
    .ld_unsigned (ld_unsigned),
    .ld_rdata    (ld_rdata),
    .ld_result   (ld_result),
    .ld_done     (ld_done),
    .ld_misalign (ld_misalign)
);

// File: tb/lsu_align_tb_top.sv
`timescale 1ns/1ps
module lsu_align_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_req = 1'b0;
    logic [31:0] st_addr = '0;
    logic [1:0]  st_size = '0;
    logic [31:0] st_data = '0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic        st_misalign;
    logic        ld_req = 1'b0;
    logic [1:0]  ld_addr_lo = '0;
    logic [1:0]  ld_size = '0;
    logic        ld_unsigned = 1'b0;
    logic [31:0] ld_rdata = '0;
    logic [31:0] ld_result;
    logic        ld_done;
    logic        ld_misalign;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lsu_align #(.ADDR_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_req(st_req), .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .st_misalign(st_misalign),
        .ld_req(ld_req), .ld_addr_lo(ld_addr_lo), .ld_size(ld_size),
        .ld_unsigned(ld_unsigned), .ld_rdata(ld_rdata),
        .ld_result(ld_result), .ld_done(ld_done), .ld_misalign(ld_misalign)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic is_mis(logic [1:0] sz, logic [1:0] off);
        case (sz)
            2'b00:   return 1'b0;
            2'b01:   return off[0];
            2'b10:   return off != 2'b00;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] off);
        if (is_mis(sz, off)) return 4'b0000;
        case (sz)
            2'b00:   return 4'b0001 << off;
            2'b01:   return off[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_wd(logic [1:0] sz, logic [31:0] d);
        case (sz)
            2'b00:   return {4{d[7:0]}};
            2'b01:   return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] exp_ld(logic [1:0] sz, logic [1:0] off,
                                           logic u, logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        if (is_mis(sz, off)) return 32'h0;
        b = w[8*off +: 8];
        h = off[1] ? w[31:16] : w[15:0];
        case (sz)
            2'b00:   return u ? {24'h0, b} : {{24{b[7]}}, b};
            2'b01:   return u ? {16'h0, h} : {{16{h[15]}}, h};
            default: return w;
        endcase
    endfunction

    // One store request, result sampled 1 ns after the registering edge.
    task automatic do_store(logic [31:0] a, logic [1:0] sz, logic [31:0] d,
                            string tag);
        @(negedge clk);
        st_req = 1'b1; st_addr = a; st_size = sz; st_data = d;
        @(posedge clk); #1;
        st_req = 1'b0;
        check({tag, " R2/R5 mask"}, {28'h0, mem_be}, {28'h0, exp_be(sz, a[1:0])});
        check({tag, " R3 wdata"}, mem_wdata, exp_wd(sz, d));
        check({tag, " R4 addr"}, mem_addr, {a[31:2], 2'b00});
        check({tag, " R5 we"}, {31'h0, mem_we}, {31'h0, !is_mis(sz, a[1:0])});
        check({tag, " R5 mis"}, {31'h0, st_misalign}, {31'h0, is_mis(sz, a[1:0])});
    endtask

    task automatic do_load(logic [1:0] off, logic [1:0] sz, logic u,
                           logic [31:0] w, string tag);
        @(negedge clk);
        ld_req = 1'b1; ld_addr_lo = off; ld_size = sz; ld_unsigned = u; ld_rdata = w;
        @(posedge clk); #1;
        ld_req = 1'b0;
        check({tag, " result"}, ld_result, exp_ld(sz, off, u, w));
        check({tag, " R9 done"}, {31'h0, ld_done}, {31'h0, !is_mis(sz, off)});
        check({tag, " R9 mis"}, {31'h0, ld_misalign}, {31'h0, is_mis(sz, off)});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 mem_addr", mem_addr, 32'h0);
        check("R1 mem_be", {28'h0, mem_be}, 32'h0);
        check("R1 mem_wdata", mem_wdata, 32'h0);
        check("R1 flags", {27'h0, mem_we, st_misalign, ld_done, ld_misalign, 1'b0}, 32'h0);
        check("R1 ld_result", ld_result, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release", {mem_addr | mem_wdata | ld_result}, 32'h0);
    endtask

    task automatic t_store_byte();
        for (int o = 0; o < 4; o++)
            do_store(32'h1000_0040 + o, 2'b00, 32'hCAFE_BEA5, "R2 R3 R4 byte");
    endtask

    task automatic t_store_half();
        do_store(32'h2000_0100, 2'b01, 32'h1234_8765, "R2 R3 half off0");
        do_store(32'h2000_0102, 2'b01, 32'h1234_8765, "R2 R3 half off2");
    endtask

    task automatic t_store_word();
        do_store(32'h3000_0FFC, 2'b10, 32'hDEAD_BEEF, "R2 R3 word");
    endtask

    task automatic t_store_mis();
        do_store(32'h4000_0001, 2'b01, 32'hAAAA_5555, "R5 half odd");
        do_store(32'h4000_0003, 2'b01, 32'hAAAA_5555, "R5 half off3");
        for (int o = 1; o < 4; o++)
            do_store(32'h4000_0010 + o, 2'b10, 32'h0F0F_F0F0, "R5 word");
        do_store(32'h4000_0020, 2'b11, 32'h1111_2222, "R10 store rsvd");
    endtask

    task automatic t_store_idle();
        logic [31:0] a_keep, d_keep;
        do_store(32'h5000_0008, 2'b10, 32'h7654_3210, "R11 prep");
        a_keep = mem_addr; d_keep = mem_wdata;
        @(negedge clk);
        st_addr = 32'hFFFF_FFF0; st_data = 32'h0BAD_0BAD; st_size = 2'b10;
        @(posedge clk); #1;
        check("R11 idle we", {31'h0, mem_we}, 32'h0);
        check("R11 idle mask", {28'h0, mem_be}, 32'h0);
        check("R11 idle mis", {31'h0, st_misalign}, 32'h0);
        check("R11 idle addr hold", mem_addr, a_keep);
        check("R11 idle data hold", mem_wdata, d_keep);
    endtask

    task automatic t_load_byte();
        for (int o = 0; o < 4; o++) begin
            do_load(o[1:0], 2'b00, 1'b0, 32'h80F1_7F82, "R6 lb");
            do_load(o[1:0], 2'b00, 1'b1, 32'h80F1_7F82, "R6 lbu");
        end
    endtask

    task automatic t_load_half();
        do_load(2'b00, 2'b01, 1'b0, 32'h7ABC_9123, "R7 lh off0");
        do_load(2'b00, 2'b01, 1'b1, 32'h7ABC_9123, "R7 lhu off0");
        do_load(2'b10, 2'b01, 1'b0, 32'h9ABC_1123, "R7 lh off2");
        do_load(2'b10, 2'b01, 1'b1, 32'h9ABC_1123, "R7 lhu off2");
        do_load(2'b10, 2'b01, 1'b0, 32'h7ABC_F123, "R7 lh off2 pos");
    endtask

    task automatic t_load_word();
        do_load(2'b00, 2'b10, 1'b0, 32'hF00D_1234, "R8 lw");
        do_load(2'b00, 2'b10, 1'b1, 32'h800D_1234, "R8 lw uns");
    endtask

    task automatic t_load_mis();
        logic [31:0] keep;
        do_load(2'b01, 2'b01, 1'b0, 32'hFFFF_FFFF, "R9 lh odd");
        do_load(2'b10, 2'b10, 1'b1, 32'hFFFF_FFFF, "R9 lw off2");
        do_load(2'b00, 2'b11, 1'b0, 32'hFFFF_FFFF, "R10 load rsvd");
        do_load(2'b00, 2'b10, 1'b0, 32'h1357_9BDF, "R11 prep load");
        keep = ld_result;
        @(negedge clk); ld_rdata = 32'h0;
        @(posedge clk); #1;
        check("R11 load idle done", {30'h0, ld_done, ld_misalign}, 32'h0);
        check("R11 load idle hold", ld_result, keep);
    endtask

    initial begin
        t_reset();
        t_store_byte();
        t_store_half();
        t_store_word();
        t_store_mis();
        t_store_idle();
        t_load_byte();
        t_load_half();
        t_load_word();
        t_load_mis();
        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule